// File: doc/BRIEF.md
# Fuse Row Read Access Filter

This block sits between a register interface and a one-time-programmable fuse store. Software writes a read-address word that names a fuse array and a row. The block decides from a fixed permission table whether that row may be read, and which of its 32 columns are visible. A permitted read fetches the row through a row-read port and keeps only the visible columns. A denied read never reaches the store.

The result lands in a read-data register that the bus can only read. A one-cycle done pulse marks a permitted read; an error flag marks a denied one. Array number 1 is not present in the store. The address values 2 and 3 therefore map onto physical arrays 1 and 2, and those arrays have every column readable. Only one fetch is in flight at a time, and address writes arriving while one is outstanding are dropped.

Top module: `fuse_rd_filter`

## Requirements
- R1: The address word carries the array number in bits 12:11 and the row in bits 10:5. Bits 4:0 and bits above 12 have no effect on the outcome.
- R2: In array 0, each row exposes only these columns: row 0 bits 28..31; rows 8..15 all; row 16 bits 0..7 and 10..16; row 17 bits 0..2; row 20 all; row 21 bits 0..23 and 29..31; rows 22 and 23 all; rows 40..63 all.
- R3: A row of array 0 that exposes no column is denied.
- R4: Address array values 2 and 3 are issued on the row port as arrays 1 and 2, with all 32 columns exposed. Address array value 1 is denied.
- R5: A permitted read loads the fetched row ANDed with the row's column mask into read-data, clears the error flag and pulses done high for exactly one cycle.
- R6: A denied read issues no row request, loads zero into read-data, sets the error flag and leaves done low.
- R7: The row request is high for one cycle, in the cycle after the clock edge that accepts the address write. The result is visible after the second edge following the accepting edge.
- R8: An address write made while a read is outstanding is ignored and produces no second result.
- R9: After reset, read-data is zero, and the error flag, done and the row request are all low.
- R10: Read-data and the error flag change only when a read completes. They are not writable from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_wr | input | 1 | Write strobe for the read-address word |
| ra_wdata | input | 32 | Read-address word being written |
| row_req | output | 1 | Row fetch request to the fuse store |
| row_arr | output | 2 | Remapped physical array of the fetch |
| row_sel | output | 6 | Row of the fetch |
| row_rdata | input | 32 | Row returned by the store one cycle after the request |
| rd_data | output | 32 | Read-data register (masked row, or zero when denied) |
| rd_done | output | 1 | One-cycle pulse after a permitted read |
| rd_err | output | 1 | Set by a denied read, cleared by a permitted read |

## Verification
The assertions assume that the store presents the requested row on row_rdata in the cycle after row_req, and that the row holds steady through that cycle. The bench models the store as a single register loaded on the request edge, which meets that assumption by construction. The bench sweeps every array and row value twice. One pass uses an all-ones store, so each column mask appears directly in read-data. The other pass uses a store whose contents are an arithmetic hash of the address. Extra writes are placed in both waiting cycles of an outstanding read, and one address word has its reserved bits set.

// File: rtl/fuse_rd_filter.sv
module fuse_rd_filter #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int ARR_W   = 2,
  parameter int ROW_W   = 6,
  parameter int ROW_LSB = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ra_wr,
  input  logic [AW-1:0]    ra_wdata,
  output logic             row_req,
  output logic [ARR_W-1:0] row_arr,
  output logic [ROW_W-1:0] row_sel,
  input  logic [DW-1:0]    row_rdata,
  output logic [DW-1:0]    rd_data,
  output logic             rd_done,
  output logic             rd_err
);

  localparam int ARR_LSB = ROW_LSB + ROW_W;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  st_t st;

  function automatic logic [DW-1:0] span(input int lo, input int hi);
    logic [DW-1:0] m;
    for (int i = 0; i < DW; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction

  function automatic logic [DW-1:0] arr0_mask(input logic [ROW_W-1:0] r);
    int ri;
    ri = int'(r);
    if (ri == 0)                  return span(28, 31);
    if (ri >= 8 && ri <= 15)      return '1;
    if (ri == 16)                 return span(0, 7) | span(10, 16);
    if (ri == 17)                 return span(0, 2);
    if (ri == 20)                 return '1;
    if (ri == 21)                 return span(0, 23) | span(29, 31);
    if (ri == 22 || ri == 23)     return '1;
    if (ri >= 40)                 return '1;
    return '0;
  endfunction

  wire [ARR_W-1:0] a_in = ra_wdata[ARR_LSB +: ARR_W];
  wire [ROW_W-1:0] r_in = ra_wdata[ROW_LSB +: ROW_W];

  logic [DW-1:0]    mask_in;
  logic [ARR_W-1:0] phys_in;
  always_comb begin
    mask_in = '0;
    phys_in = '0;
    case (int'(a_in))
      0:       mask_in = arr0_mask(r_in);
      2, 3: begin
        mask_in = '1;
        phys_in = a_in - ARR_W'(1);
      end
      default: mask_in = '0;
    endcase
  end

  wire acc = ra_wr && (st == S_IDLE);

  logic [ARR_W-1:0] arr_q;
  logic [ROW_W-1:0] row_q;
  logic [DW-1:0]    mask_q;
  logic             ok_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      arr_q  <= '0;
      row_q  <= '0;
      mask_q <= '0;
      ok_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE:  if (acc) begin
          st     <= S_ISSUE;
          arr_q  <= phys_in;
          row_q  <= r_in;
          mask_q <= mask_in;
          ok_q   <= |mask_in;
        end
        S_ISSUE: st <= S_WAIT;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign row_req = (st == S_ISSUE) && ok_q;
  assign row_arr = arr_q;
  assign row_sel = row_q;

  wire fin = (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_done <= 1'b0;
      rd_err  <= 1'b0;
    end else begin
      rd_done <= fin && ok_q;
      if (fin) begin
        rd_data <= ok_q ? (row_rdata & mask_q) : '0;
        rd_err  <= !ok_q;
      end
    end
  end

  AST_ARR_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    row_req |-> (int'(row_arr) <= 2)); // R4
  AST_DENY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (rd_data == '0)); // R6
  AST_DONE_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !rd_err); // R5
  AST_DONE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> ((rd_data & ~mask_q) == '0)); // R2
  AST_REQ_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    row_req |-> $past(acc)); // R7
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    row_req |=> !row_req); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_wr && st != S_IDLE) |=> ($stable(arr_q) && $stable(row_q) && $stable(mask_q))); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(rd_data) && $stable(rd_err))); // R10

endmodule

// File: tb/sim_fuse_rd_filter.sv
`timescale 1ns/1ps
module sim_fuse_rd_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        ra_wr = 0;
  logic [31:0] ra_wdata = '0;
  logic        row_req;
  logic [1:0]  row_arr;
  logic [5:0]  row_sel;
  logic [31:0] row_rdata;
  logic [31:0] rd_data;
  logic        rd_done, rd_err;

  int n_chk = 0, n_bad = 0;
  int pass_sel = 0;

  always #2 clk = ~clk;

  fuse_rd_filter u0 (
    .clk(clk), .rst_n(rst_n), .ra_wr(ra_wr), .ra_wdata(ra_wdata),
    .row_req(row_req), .row_arr(row_arr), .row_sel(row_sel),
    .row_rdata(row_rdata), .rd_data(rd_data), .rd_done(rd_done), .rd_err(rd_err)
  );

  function automatic logic [31:0] store(input int a, input int r);
    if (pass_sel == 0) return 32'hFFFF_FFFF;
    return (32'h9E37_79B9 * (a * 64 + r + 1)) ^ 32'h5A5A_5A5A;
  endfunction

  always_ff @(posedge clk) if (row_req) row_rdata <= store(int'(row_arr), int'(row_sel));

  function automatic logic [31:0] rng(input int lo, input int hi);
    logic [63:0] v;
    v = ((64'd1 << (hi - lo + 1)) - 64'd1) << lo;
    return v[31:0];
  endfunction

  function automatic logic [31:0] exp_mask(input int a, input int r);
    if (a == 2 || a == 3) return 32'hFFFF_FFFF;
    if (a != 0) return 32'h0;
    case (r)
      0: return rng(28, 31);
      16: return rng(0, 7) | rng(10, 16);
      17: return rng(0, 2);
      20, 22, 23: return 32'hFFFF_FFFF;
      21: return rng(0, 23) | rng(29, 31);
      default: return ((r >= 8 && r <= 15) || r >= 40) ? 32'hFFFF_FFFF : 32'h0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input int a, input int r, input logic [31:0] extra, input int stray);
    logic [31:0] m, d;
    bit ok;
    m  = exp_mask(a, r);
    ok = (m != 0);
    d  = ok ? (store(a == 0 ? 0 : a - 1, r) & m) : 32'h0;
    @(negedge clk);
    ra_wr = 1; ra_wdata = extra | (32'(a) << 11) | (32'(r) << 5);
    @(negedge clk);
    ra_wr = (stray == 1); ra_wdata = {19'h0, 2'(3 - a), 6'(r ^ 6'h15), 5'h0};
    chk(row_req == ok, "R7 req", 32'(row_req), 32'(ok));
    if (ok) begin
      chk(row_sel == 6'(r), "R1 row", 32'(row_sel), 32'(r));
      chk(int'(row_arr) == (a == 0 ? 0 : a - 1), "R4 arr", 32'(row_arr), 32'(a == 0 ? 0 : a - 1));
    end
    @(negedge clk);
    ra_wr = (stray == 2);
    chk(row_req == 0, "R7 single", 32'(row_req), 0);
    chk(rd_done == 0, "R7 early", 32'(rd_done), 0);
    @(negedge clk);
    ra_wr = 0;
    chk(rd_data == d, ok ? "R5 data" : "R6 data", rd_data, d);
    chk(rd_err == !ok, ok ? "R5 err" : "R3 err", 32'(rd_err), 32'(!ok));
    chk(rd_done == ok, ok ? "R5 done" : "R6 done", 32'(rd_done), 32'(ok));
    @(negedge clk);
    chk(rd_done == 0, "R5 pulse", 32'(rd_done), 0);
    chk(row_req == 0, "R8 no refetch", 32'(row_req), 0);
    if (stray != 0) begin
      @(negedge clk);
      chk(rd_data == d && rd_err == !ok, "R8 ignored", rd_data, d);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_data == 0, "R9 data", rd_data, 0);
    chk(rd_done == 0 && rd_err == 0 && row_req == 0, "R9 flags",
        {29'h0, rd_done, rd_err, row_req}, 0);
    rst_n = 1;
    for (int p = 0; p < 2; p++) begin
      pass_sel = p;
      for (int a = 0; a < 4; a++)
        for (int r = 0; r < 64; r++) do_read(a, r, 32'h0, 0);
    end
    do_read(0, 21, 32'hFFFF_E01F, 0);  // R1 reserved bits
    do_read(2, 7, 32'h0, 1);           // R8 write in request cycle
    do_read(0, 16, 32'h0, 2);          // R8 write in wait cycle
    do_read(1, 9, 32'h0, 1);           // R8 while denied
    do_read(0, 5, 32'h0, 0);           // R10 error from a denied read
    @(negedge clk);
    chk(rd_err == 1 && rd_data == 0, "R10 hold", rd_data, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule